// File: doc/BRIEF.md
# Synchronous External Memory Bus Controller

This controller turns internal memory requests into bus cycles on an external 16-bit memory bus whose address and data lines are separate. A request carries a size (byte, halfword or 32-bit word), an address, write data, a direction and the index of one of several chip-select blocks. The controller drives an active-low chip select for the chosen block, an active-low read strobe, two active-low byte write strobes, the address and the write data. It returns read data together with a one-cycle completion pulse.

The block runs on the fast bus clock. The system clock is 1, 2 or 4 times slower, and its rising edge is tracked by a phase counter that restarts at reset. Each block has its own static configuration field. The field gives the bus-clock phase, inside a system-clock period, at which a bus cycle opens, and a fixed number of wait cycles after which it closes. No ready input exists. A 32-bit request is carried out as two 16-bit bus cycles, the lower halfword first.

Top module: `sync_mem_bus_ctrl`

## Requirements
- R1: After reset, every chip select, the read strobe and both write strobes are high, `doe_o` is low, `dout_o` is zero and `done_o` is low.
- R2: The cycle in which a request is presented is its acceptance cycle. The phase of a cycle is the number of bus-clock edges since reset release, modulo the ratio. A bus cycle first becomes active in the earliest cycle, at least two after the acceptance cycle, whose phase equals the block's start field masked by ratio−1. Block i owns `cfg_i[6i+5:6i]`, and its start field is bits [1:0] of that slice.
- R3: A bus cycle stays active for exactly n+1 bus-clock cycles, where n is bits [5:2] of the block's slice.
- R4: `ratio_i` encodes the bus-clock to system-clock ratio: 0 means 1, 1 means 2, and 2 or 3 mean 4.
- R5: Only `cs_n_o[blk]` is low, and only in active cycles. The address is stable for the whole of a bus cycle. Outside active cycles all strobes are high.
- R6: A read drives `re_n_o` low in active cycles, keeps both write strobes high and keeps `doe_o` low.
- R7: A byte write drives `we_n_o[0]` low when address bit 0 is 0, and `we_n_o[1]` low when it is 1. The byte `wdata[7:0]` appears on both halves of `dout_o`.
- R8: A halfword write drives both write strobes low and puts `wdata[15:0]` on `dout_o`. For halfword and word accesses, address bit 0 is output as 0.
- R9: A word access makes two bus cycles, with address bit 1 at 0 and then at 1, carrying `wdata[15:0]` and then `wdata[31:16]`. The second cycle realigns to the start phase, and at least one inactive cycle separates the two.
- R10: Read data is sampled from `din_i` in the last active cycle of each bus cycle. `rdata_o` is valid with `done_o`: a byte read gives the zero-extended byte from the lane selected by address bit 0, a halfword read gives the zero-extended halfword, and a word read gives {second, first}.
- R11: `done_o` is high for exactly one cycle, the one after the last active cycle of the request.
- R12: `doe_o` is high only in active write cycles. `dout_o` is zero whenever `doe_o` is low.
- R13: A request presented while a transfer is in progress is ignored and leaves the running transfer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 2 | Bus-clock to system-clock ratio code |
| cfg_i | input | NUM_CS*6 | Per-block start phase and wait count |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_blk_i | input | $clog2(NUM_CS) | Chip-select block index |
| din_i | input | 16 | External read data |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| re_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 2 | Byte write strobes, active low |
| addr_o | output | AW | External address |
| dout_o | output | 16 | External write data |
| doe_o | output | 1 | Write data output enable |
| rdata_o | output | 32 | Assembled read data |
| done_o | output | 1 | Completion pulse |

## Verification
The bench builds the block with its defaults: four blocks, a 16-bit address, 2-bit start fields and 4-bit wait fields. Because the ratio is a run-time input, one build covers all three ratios and the fourth code. The four blocks are given different start phases and wait counts. This exercises phase masking under every ratio, single-cycle and multi-cycle bus cycles, and the realignment of the second half of a word access to a phase other than zero.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } state_e;

  localparam int unsigned PH_W = 2;
endpackage

// File: rtl/smb_phase.sv
module smb_phase
  import smb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      ratio_i,
  input  logic [PH_W-1:0] bcs_i,
  output logic            hit_o
);
  logic [PH_W-1:0] ph_q, ph_nxt, lim;

  always_comb begin
    unique case (ratio_i)
      2'd0:    lim = 2'd0;
      2'd1:    lim = 2'd1;
      default: lim = 2'd3;
    endcase
  end

  assign ph_nxt = (ph_q >= lim) ? '0 : ph_q + 1'b1;
  // next cycle lands on the programmed phase
  assign hit_o  = (ph_nxt == (bcs_i & lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_nxt;
  end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned BCE_W = 4,
  parameter int unsigned BLK_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  size_e            req_size_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [31:0]      req_wdata_i,
  input  logic [BLK_W-1:0] req_blk_i,
  input  logic             start_i,
  input  logic [BCE_W-1:0] bce_i,
  input  logic [15:0]      din_i,
  output logic             act_o,
  output logic             half_o,
  output logic             we_o,
  output size_e            size_o,
  output logic [AW-1:0]    addr_o,
  output logic [31:0]      wdata_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [15:0]      lo_o,
  output logic [15:0]      hi_o,
  output logic             done_o
);
  state_e           st_q;
  logic [BCE_W-1:0] cnt_q;
  logic             last_cyc;

  assign last_cyc = (st_q == ST_RUN) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      act_o   <= 1'b0;
      half_o  <= 1'b0;
      we_o    <= 1'b0;
      size_o  <= SZ_BYTE;
      addr_o  <= '0;
      wdata_o <= '0;
      blk_o   <= '0;
      lo_o    <= '0;
      hi_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            we_o    <= req_we_i;
            size_o  <= req_size_i;
            addr_o  <= req_addr_i;
            wdata_o <= req_wdata_i;
            blk_o   <= req_blk_i;
            half_o  <= 1'b0;
            st_q    <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (start_i) begin
            act_o <= 1'b1;
            cnt_q <= bce_i;
            st_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_cyc) begin
            act_o <= 1'b0;
            if (half_o) hi_o <= din_i;
            else        lo_o <= din_i;
            if (size_o == SZ_WORD && !half_o) begin
              half_o <= 1'b1;
              st_q   <= ST_ARM;
            end else begin
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_lane.sv
module smb_lane
  import smb_pkg::*;
(
  input  logic        act_i,
  input  logic        we_i,
  input  size_e       size_i,
  input  logic        addr0_i,
  input  logic        half_i,
  input  logic [31:0] wdata_i,
  input  logic [15:0] lo_i,
  input  logic [15:0] hi_i,
  output logic        re_n_o,
  output logic [1:0]  we_n_o,
  output logic        doe_o,
  output logic [15:0] dout_o,
  output logic [31:0] rdata_o
);
  logic [15:0] wr_half;

  assign wr_half = (size_i == SZ_WORD && half_i) ? wdata_i[31:16] : wdata_i[15:0];

  always_comb begin
    re_n_o = 1'b1;
    we_n_o = 2'b11;
    doe_o  = 1'b0;
    dout_o = '0;
    if (act_i) begin
      if (!we_i) begin
        re_n_o = 1'b0;
      end else begin
        doe_o = 1'b1;
        if (size_i == SZ_BYTE) begin
          we_n_o = addr0_i ? 2'b01 : 2'b10;
          dout_o = {wdata_i[7:0], wdata_i[7:0]};
        end else begin
          we_n_o = 2'b00;
          dout_o = wr_half;
        end
      end
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: rdata_o = {24'b0, addr0_i ? lo_i[15:8] : lo_i[7:0]};
      SZ_HALF: rdata_o = {16'b0, lo_i};
      default: rdata_o = {hi_i, lo_i};
    endcase
  end
endmodule

// File: rtl/sync_mem_bus_ctrl.sv
module sync_mem_bus_ctrl
  import smb_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned AW     = 16,
  parameter int unsigned BCE_W  = 4,
  localparam int unsigned BLK_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned CFG_W = PH_W + BCE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              ratio_i,
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [1:0]              req_size_i,
  input  logic [AW-1:0]           req_addr_i,
  input  logic [31:0]             req_wdata_i,
  input  logic [BLK_W-1:0]        req_blk_i,
  input  logic [15:0]             din_i,
  output logic [NUM_CS-1:0]       cs_n_o,
  output logic                    re_n_o,
  output logic [1:0]              we_n_o,
  output logic [AW-1:0]           addr_o,
  output logic [15:0]             dout_o,
  output logic                    doe_o,
  output logic [31:0]             rdata_o,
  output logic                    done_o
);
  logic [CFG_W-1:0] cfg_a [NUM_CS];
  logic [CFG_W-1:0] cfg_sel;
  logic             act, half, we, start;
  size_e            size;
  logic [AW-1:0]    addr_q;
  logic [31:0]      wdata_q;
  logic [BLK_W-1:0] blk_q;
  logic [15:0]      lo_q, hi_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_blk
    assign cfg_a[g]  = cfg_i[g*CFG_W +: CFG_W];
    assign cs_n_o[g] = !(act && (blk_q == BLK_W'(g)));
  end

  assign cfg_sel = cfg_a[blk_q];

  smb_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_i),
    .bcs_i   (cfg_sel[PH_W-1:0]),
    .hit_o   (start)
  );

  smb_seq #(.AW(AW), .BCE_W(BCE_W), .BLK_W(BLK_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_size_i  (size_e'(req_size_i)),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .req_blk_i   (req_blk_i),
    .start_i     (start),
    .bce_i       (cfg_sel[CFG_W-1:PH_W]),
    .din_i       (din_i),
    .act_o       (act),
    .half_o      (half),
    .we_o        (we),
    .size_o      (size),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q),
    .blk_o       (blk_q),
    .lo_o        (lo_q),
    .hi_o        (hi_q),
    .done_o      (done_o)
  );

  smb_lane u_lane (
    .act_i   (act),
    .we_i    (we),
    .size_i  (size),
    .addr0_i (addr_q[0]),
    .half_i  (half),
    .wdata_i (wdata_q),
    .lo_i    (lo_q),
    .hi_i    (hi_q),
    .re_n_o  (re_n_o),
    .we_n_o  (we_n_o),
    .doe_o   (doe_o),
    .dout_o  (dout_o),
    .rdata_o (rdata_o)
  );

  assign addr_o = {addr_q[AW-1:2],
                   (size == SZ_WORD) ? half : addr_q[1],
                   (size == SZ_BYTE) ? addr_q[0] : 1'b0};
endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned AW     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic              re_n_o,
  input logic [1:0]        we_n_o,
  input logic [AW-1:0]     addr_o,
  input logic [15:0]       dout_o,
  input logic              doe_o,
  input logic              done_o
);
  logic any_cs;
  assign any_cs = (cs_n_o != {NUM_CS{1'b1}});

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_cs |-> (re_n_o && we_n_o == 2'b11 && !doe_o)); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_cs && $past(any_cs)) |-> $stable(addr_o)); // R5
  AST_READ_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_n_o |-> (we_n_o == 2'b11 && !doe_o)); // R6
  AST_DOE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doe_o |-> (we_n_o != 2'b11 && any_cs)); // R12
  AST_DOUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doe_o |-> dout_o == 16'h0); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AFTER_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!any_cs && $past(any_cs))); // R11
endmodule

bind sync_mem_bus_ctrl smb_checker #(.NUM_CS(NUM_CS), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_o (cs_n_o),
  .re_n_o (re_n_o),
  .we_n_o (we_n_o),
  .addr_o (addr_o),
  .dout_o (dout_o),
  .doe_o  (doe_o),
  .done_o (done_o)
);

// File: tb/sync_mem_bus_ctrl_tb.sv
module sync_mem_bus_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int NUM_CS = 4;
  localparam int AW     = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0]  ratio;
  logic [23:0] cfg;
  logic        req_valid, req_we;
  logic [1:0]  req_size, req_blk;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic [15:0] din;
  logic [NUM_CS-1:0] cs_n;
  logic        re_n, doe, done;
  logic [1:0]  we_n;
  logic [AW-1:0] addr;
  logic [15:0] dout;
  logic [31:0] rdata;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  sync_mem_bus_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .cfg_i(cfg),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_blk_i(req_blk),
    .din_i(din), .cs_n_o(cs_n), .re_n_o(re_n), .we_n_o(we_n),
    .addr_o(addr), .dout_o(dout), .doe_o(doe), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic int bcs_of(int b); return (cfg >> (6*b)) & 3; endfunction
  function automatic int bce_of(int b); return (cfg >> (6*b + 2)) & 15; endfunction
  function automatic int ratio_val(); return (ratio == 0) ? 1 : (ratio == 1) ? 2 : 4; endfunction

  task automatic do_reset(input logic [1:0] r);
    @(negedge clk);
    rst_n = 0; ratio = r; req_valid = 0; din = 0;
    repeat (2) @(negedge clk);
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 strobes", {29'b0, re_n, we_n}, 32'h7);
    chk("R1 doe/done", {30'b0, doe, done}, 0);
    chk("R1 dout", 32'(dout), 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  // One transfer, compared against the expected bus picture every cycle.
  task automatic txn(input int sz, input bit wr, input logic [AW-1:0] a,
                     input logic [31:0] wd, input int b,
                     input logic [15:0] dlo, input logic [15:0] dhi,
                     input bit spurious);
    int rr, ph, c, t0, e0, t1, e1, dc;
    bit word;
    rr = ratio_val();
    ph = bcs_of(b) & (rr - 1);
    word = (sz == 2);
    c = cyc;
    t0 = c + 2; while (t0 % rr != ph) t0++;
    e0 = t0 + bce_of(b);
    t1 = e0 + 2; while (t1 % rr != ph) t1++;
    e1 = t1 + bce_of(b);
    dc = (word ? e1 : e0) + 1;
    for (int k = c; k <= dc; k++) begin
      bit act, h;
      logic [3:0]  ecs;
      logic [1:0]  ewe;
      logic [15:0] edo;
      logic [AW-1:0] ea;
      h   = word && k >= t1;
      act = (k >= t0 && k <= e0) || (word && k >= t1 && k <= e1);
      din = h ? dhi : dlo;
      req_valid = (k == c) || (spurious && k == t0);
      if (k == c) begin
        req_we = wr; req_size = 2'(sz); req_addr = a; req_wdata = wd; req_blk = 2'(b);
      end else if (spurious && k == t0) begin // R13: garbage request while busy
        req_we = !wr; req_size = 2'd1; req_addr = ~a; req_wdata = ~wd; req_blk = 2'(b + 1);
      end
      ecs = 4'hF; ewe = 2'b11; edo = 0; ea = a;
      if (act) begin
        ecs[b] = 1'b0;
        if (wr) begin
          if (sz == 0) begin ewe = a[0] ? 2'b01 : 2'b10; edo = {wd[7:0], wd[7:0]}; end
          else begin ewe = 2'b00; edo = h ? wd[31:16] : wd[15:0]; end
        end
        ea[1] = word ? h : a[1];
        ea[0] = (sz == 0) ? a[0] : 1'b0;
      end
      #1;
      chk(spurious ? "R13 cs_n" : "R2/R3/R5 cs_n", 32'(cs_n), 32'(ecs));
      chk("R6 re_n", 32'(re_n), 32'(!(act && !wr)));
      chk("R7/R8 we_n", 32'(we_n), 32'(ewe));
      chk("R12 doe", 32'(doe), 32'(act && wr));
      chk("R7/R8/R9 dout", 32'(dout), 32'(edo));
      chk("R11 done", 32'(done), 32'(k == dc));
      if (act) chk(word ? "R9 addr" : "R5 addr", 32'(addr), 32'(ea));
      if (k == dc && !wr) begin
        logic [31:0] er;
        er = (sz == 0) ? {24'b0, a[0] ? dlo[15:8] : dlo[7:0]} :
             (sz == 1) ? {16'b0, dlo} : {dhi, dlo};
        chk("R10 rdata", rdata, er);
      end
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  task automatic suite();
    txn(0, 1, 16'h1230, 32'h0000_00A5, 0, 0, 0, 0);          // R7 lane0
    txn(0, 1, 16'h1231, 32'h0000_005C, 1, 0, 0, 0);          // R7 lane1
    txn(1, 1, 16'h2002, 32'h0000_BEEF, 2, 0, 0, 0);          // R8
    txn(2, 1, 16'h3006, 32'hCAFE_F00D, 3, 0, 0, 0);          // R9
    txn(0, 0, 16'h4001, 0, 1, 16'h9A3C, 0, 0);               // R10 byte hi lane
    txn(0, 0, 16'h4000, 0, 2, 16'h9A3C, 0, 0);               // R10 byte lo lane
    txn(1, 0, 16'h5003, 0, 0, 16'h7E81, 0, 0);               // R10 half, R8 addr bit0
    txn(2, 0, 16'h6004, 0, 3, 16'h1111, 16'h2222, 1);        // R10 word, R13
    txn(2, 0, 16'h6000, 0, 1, 16'hABCD, 16'h0123, 0);        // R2 realign
  endtask

  initial begin
    // blk0: ph0 n0, blk1: ph1 n2, blk2: ph3 n1, blk3: ph2 n3
    cfg = {4'd3, 2'd2, 4'd1, 2'd3, 4'd2, 2'd1, 4'd0, 2'd0};
    req_valid = 0; req_we = 0; req_size = 0; req_addr = 0; req_wdata = 0; req_blk = 0; din = 0;
    ratio = 0;
    do_reset(2'd0); suite();     // R4 ratio 1
    do_reset(2'd1); suite();     // R4 ratio 2
    do_reset(2'd2); suite();     // R4 ratio 4
    do_reset(2'd3);              // R4 code 3 behaves as 4
    txn(2, 1, 16'h7000, 32'h5555_AAAA, 2, 0, 0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule